// File: doc/BRIEF.md
# Channel-Interleave Address Swizzle Unit

This block is one pipelined stage on the address path between a tiled-surface client and dual-channel memory. When memory is interleaved, bit 6 of a byte address picks the channel, because consecutive 64-byte blocks go to alternate channels. The graphics engine and the CPU choose that bit in different ways. The graphics engine folds tile-row bits into bit 6. The CPU may also fold in a higher "randomization" bit. The unit takes one memory-controller configuration word and works out a bit-6 swizzle mode for X-tiled surfaces and another for Y-tiled surfaces. It then rewrites bit 6 of every tiled request to match.

Each request carries a byte address and a tiling kind. After one register stage, the unit returns the adjusted address and a flag that marks the surface as unsafe to tile. A surface is unsafe when its mode depends on a bit above the 4 KiB page offset, or when the configuration could not be read. Requests and responses use valid/ready handshakes. A configuration write is sampled on the clock edge and applies to requests accepted in later cycles.

Top module: `swz_unit`

Configuration word fields:
- bits [1:0]: addressing mode. 0 is single channel, 1 is asymmetric dual channel, 2 is interleaved dual channel, 3 is reserved.
- bit 2: disables the CPU channel XOR.
- bit 3: selects the CPU XOR source. 0 selects address bit 11 and 1 selects address bit 17.
- bit 4: the per-channel DIMM sizes are equal.
- bit 5: derive the modes from DIMM size equality instead of from the addressing mode.

Tiling kind encoding: 0 is linear, 1 is X, 2 is Y, 3 is reserved and is treated as linear.

## Requirements
- R1: A linear request (tiling kind 0 or 3) returns its address unchanged with the unsafe flag low, in every configuration.
- R2: With addressing mode 0, 1 or 3 (and bit 5 clear), tiled requests return unchanged and safe.
- R3: With addressing mode 2 and bit 2 set, output bit 6 for X requests is addr[6]^addr[9]^addr[10], and for Y requests is addr[6]^addr[9]. The unsafe flag is low.
- R4: With addressing mode 2, bit 2 clear and bit 3 clear, the R3 patterns also XOR addr[11] into bit 6. The unsafe flag is low.
- R5: With addressing mode 2, bit 2 clear and bit 3 set, the R3 patterns also XOR addr[17] into bit 6, and the unsafe flag is high for X and Y requests.
- R6: With bit 5 set, bit 4 set gives the R3 patterns (safe), and bit 4 clear leaves tiled requests unchanged and safe, whatever bits [3:0] hold.
- R7: A configuration word of all ones marks the mode unknown: tiled requests return unchanged with the unsafe flag high.
- R8: No output address bit other than bit 6 ever differs from the request address.
- R9: req_ready equals !rsp_valid || rsp_ready. An accepted request appears on the response one cycle later, and the response holds stable while rsp_ready is low.
- R10: A request accepted in the same cycle as a configuration write uses the previous configuration. Later requests use the new one.
- R11: After reset, rsp_valid is low, req_ready is high, and the configuration acts as single channel (no swizzle).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_word | input | CW (32) | Memory-controller configuration word |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request can be accepted |
| req_addr | input | AW (32) | Request byte address |
| req_tile | input | 2 | Tiling kind |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_addr | output | AW (32) | Swizzled byte address |
| rsp_unsafe | output | 1 | Tiling-unsafe flag |

## Verification
The assertions cover the rules that hold in every cycle: the handshake and stall-hold rules, the one-cycle latency, the pass-through of linear requests, and the fact that only bit 6 can change. The XOR patterns for each configuration cannot be expressed that way; bench scenarios show them. The same goes for the unsafe flag for bit-17 and unreadable configurations, the override by the size-derived method, and whether a configuration write in the same cycle as a request takes effect for it. The bench checks these with directed addresses that toggle bits 9, 10, 11 and 17 one at a time, and with random configurations and addresses.

// File: rtl/swz_pkg.sv
package swz_pkg;

    // Address bit positions involved in channel selection
    localparam int CH_BIT     = 6;   // channel select bit (64-byte interleave)
    localparam int ROW_BIT    = 9;   // flips every X-tile row
    localparam int PAIR_BIT   = 10;  // flips every two X-tile rows
    localparam int CPU_LO_BIT = 11;  // CPU randomization source, low choice
    localparam int CPU_HI_BIT = 17;  // CPU randomization source, above page offset

    // Configuration word field positions
    localparam int FLD_AMODE   = 0;  // 2 bits
    localparam int FLD_XOR_OFF = 2;
    localparam int FLD_HI_SEL  = 3;
    localparam int FLD_SIZE_EQ = 4;
    localparam int FLD_BY_SIZE = 5;

    typedef enum logic [1:0] {
        AM_SINGLE = 2'd0,
        AM_ASYM   = 2'd1,
        AM_INTLV  = 2'd2,
        AM_RSVD   = 2'd3
    } amode_e;

    typedef enum logic [1:0] {
        TK_LINEAR = 2'd0,
        TK_X      = 2'd1,
        TK_Y      = 2'd2,
        TK_RSVD   = 2'd3
    } tile_e;

    typedef enum logic [2:0] {
        SW_NONE     = 3'd0,
        SW_9        = 3'd1,
        SW_9_10     = 3'd2,
        SW_9_11     = 3'd3,
        SW_9_10_11  = 3'd4,
        SW_9_17     = 3'd5,
        SW_9_10_17  = 3'd6,
        SW_UNKNOWN  = 3'd7
    } swz_e;

endpackage

// File: rtl/swz_mode_decode.sv
module swz_mode_decode
    import swz_pkg::*;
#(
    parameter int CW = 32
) (
    input  logic [CW-1:0] cfg_word,
    output swz_e          x_mode,
    output swz_e          y_mode
);

    logic   all_ones;
    amode_e amode;

    assign all_ones = &cfg_word;
    assign amode    = amode_e'(cfg_word[FLD_AMODE +: 2]);

    always_comb begin
        x_mode = SW_NONE;
        y_mode = SW_NONE;
        if (all_ones) begin
            x_mode = SW_UNKNOWN;
            y_mode = SW_UNKNOWN;
        end else if (cfg_word[FLD_BY_SIZE]) begin
            if (cfg_word[FLD_SIZE_EQ]) begin
                x_mode = SW_9_10;
                y_mode = SW_9;
            end
        end else if (amode == AM_INTLV) begin
            if (cfg_word[FLD_XOR_OFF]) begin
                x_mode = SW_9_10;
                y_mode = SW_9;
            end else if (!cfg_word[FLD_HI_SEL]) begin
                x_mode = SW_9_10_11;
                y_mode = SW_9_11;
            end else begin
                x_mode = SW_9_10_17;
                y_mode = SW_9_17;
            end
        end
    end

endmodule

// File: rtl/swz_bit6_xor.sv
module swz_bit6_xor
    import swz_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [AW-1:0] addr_in,
    input  swz_e          mode,
    output logic [AW-1:0] addr_out,
    output logic          unsafe
);

    logic use_row, use_pair, use_lo, use_hi;
    logic flip;

    always_comb begin
        use_row  = 1'b0;
        use_pair = 1'b0;
        use_lo   = 1'b0;
        use_hi   = 1'b0;
        unsafe   = 1'b0;
        case (mode)
            SW_9:       use_row = 1'b1;
            SW_9_10:    begin use_row = 1'b1; use_pair = 1'b1; end
            SW_9_11:    begin use_row = 1'b1; use_lo = 1'b1; end
            SW_9_10_11: begin use_row = 1'b1; use_pair = 1'b1; use_lo = 1'b1; end
            SW_9_17:    begin use_row = 1'b1; use_hi = 1'b1; unsafe = 1'b1; end
            SW_9_10_17: begin use_row = 1'b1; use_pair = 1'b1; use_hi = 1'b1; unsafe = 1'b1; end
            SW_UNKNOWN: unsafe = 1'b1;
            default:    ;
        endcase
    end

    assign flip = (use_row  & addr_in[ROW_BIT])
                ^ (use_pair & addr_in[PAIR_BIT])
                ^ (use_lo   & addr_in[CPU_LO_BIT])
                ^ (use_hi   & addr_in[CPU_HI_BIT]);

    always_comb begin
        addr_out         = addr_in;
        addr_out[CH_BIT] = addr_in[CH_BIT] ^ flip;
    end

endmodule

// File: rtl/swz_unit.sv
module swz_unit
    import swz_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [CW-1:0] cfg_word,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [AW-1:0] req_addr,
    input  logic [1:0]    req_tile,
    output logic          rsp_valid,
    input  logic          rsp_ready,
    output logic [AW-1:0] rsp_addr,
    output logic          rsp_unsafe
);

    localparam int MIN_AW = CPU_HI_BIT + 1;

    typedef struct packed {
        swz_e          x_mode;
        swz_e          y_mode;
        logic          vld;
        logic [AW-1:0] addr;
        logic          unsafe;
    } state_t;

    state_t state_d, state_q;

    swz_e          dec_x, dec_y;
    swz_e          pick_mode;
    tile_e         tile;
    logic [AW-1:0] sw_addr;
    logic          sw_unsafe;
    logic          accept;

    initial begin
        if (AW < MIN_AW) $error("swz_unit: AW must cover address bit 17");
    end

    swz_mode_decode #(.CW(CW)) u_dec (
        .cfg_word (cfg_word),
        .x_mode   (dec_x),
        .y_mode   (dec_y)
    );

    assign tile = tile_e'(req_tile);

    always_comb begin
        case (tile)
            TK_X:    pick_mode = state_q.x_mode;
            TK_Y:    pick_mode = state_q.y_mode;
            default: pick_mode = SW_NONE;
        endcase
    end

    swz_bit6_xor #(.AW(AW)) u_xor (
        .addr_in  (req_addr),
        .mode     (pick_mode),
        .addr_out (sw_addr),
        .unsafe   (sw_unsafe)
    );

    assign req_ready = !state_q.vld || rsp_ready;
    assign accept    = req_valid && req_ready;

    always_comb begin
        state_d = state_q;
        if (cfg_we) begin
            state_d.x_mode = dec_x;
            state_d.y_mode = dec_y;
        end
        if (state_q.vld && rsp_ready) begin
            state_d.vld = 1'b0;
        end
        if (accept) begin
            state_d.vld    = 1'b1;
            state_d.addr   = sw_addr;
            state_d.unsafe = sw_unsafe;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q.x_mode <= SW_NONE;
            state_q.y_mode <= SW_NONE;
            state_q.vld    <= 1'b0;
            state_q.addr   <= '0;
            state_q.unsafe <= 1'b0;
        end else begin
            state_q <= state_d;
        end
    end

    assign rsp_valid  = state_q.vld;
    assign rsp_addr   = state_q.addr;
    assign rsp_unsafe = state_q.unsafe;

endmodule

// File: rtl/swz_unit_chk.sv
module swz_unit_chk
    import swz_pkg::*;
#(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_ready,
    input logic [AW-1:0] req_addr,
    input logic [1:0]    req_tile,
    input logic          rsp_valid,
    input logic          rsp_ready,
    input logic [AW-1:0] rsp_addr,
    input logic          rsp_unsafe
);

    localparam logic [AW-1:0] KEEP_MASK = ~(AW'(1) << CH_BIT);

    logic acc;
    logic lin;
    assign acc = req_valid && req_ready;
    assign lin = (req_tile == 2'd0) || (req_tile == 2'd3);

    a_r9_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_addr) && $stable(rsp_unsafe));

    a_r9_ready_low: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |-> !req_ready);

    a_r9_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> rsp_valid);

    a_r1_linear_pass: assert property (@(posedge clk) disable iff (!rst_n)
        acc && lin |=> rsp_addr == $past(req_addr) && !rsp_unsafe);

    a_r8_bit6_only: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> ((rsp_addr ^ $past(req_addr)) & KEEP_MASK) == '0);

endmodule

bind swz_unit swz_unit_chk #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_addr   (req_addr),
    .req_tile   (req_tile),
    .rsp_valid  (rsp_valid),
    .rsp_ready  (rsp_ready),
    .rsp_addr   (rsp_addr),
    .rsp_unsafe (rsp_unsafe)
);

// File: tb/swz_unit_test.sv
`timescale 1ns/1ps
module swz_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_word = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_tile = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b1;
    logic [31:0] rsp_addr;
    logic        rsp_unsafe;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [31:0] model_cfg = '0;

    always #2.5 clk = ~clk;

    swz_unit uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_word(cfg_word),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_tile(req_tile), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_addr(rsp_addr), .rsp_unsafe(rsp_unsafe)
    );

    // Expected {unsafe, addr} from the requirement text
    function automatic logic [32:0] expect_rsp(logic [31:0] a, logic [1:0] t, logic [31:0] w);
        logic f, u, isx;
        f = 1'b0; u = 1'b0;
        if (t == 2'd0 || t == 2'd3) return {1'b0, a};
        if (&w) return {1'b1, a};
        isx = (t == 2'd1);
        if (w[5]) begin
            if (w[4]) f = a[9] ^ (isx & a[10]);
        end else if (w[1:0] == 2'd2) begin
            f = a[9] ^ (isx & a[10]);
            if (!w[2]) begin
                if (!w[3]) f = f ^ a[11];
                else begin f = f ^ a[17]; u = 1'b1; end
            end
        end
        a[6] = a[6] ^ f;
        return {u, a};
    endfunction

    task automatic check_rsp(string tag, logic [31:0] ea, logic eu);
        checks++;
        if (rsp_valid !== 1'b1 || rsp_addr !== ea || rsp_unsafe !== eu) begin
            fails++;
            $display("FAIL %s: got v=%0b addr=%h unsafe=%0b, expected v=1 addr=%h unsafe=%0b",
                     tag, rsp_valid, rsp_addr, rsp_unsafe, ea, eu);
        end
    endtask

    task automatic write_cfg(logic [31:0] w);
        @(negedge clk);
        cfg_we = 1'b1; cfg_word = w;
        @(negedge clk);
        cfg_we = 1'b0;
        model_cfg = w;
    endtask

    task automatic one_req(string tag, logic [31:0] a, logic [1:0] t, logic [31:0] ea, logic eu);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_tile = t;
        @(negedge clk);
        req_valid = 1'b0;
        check_rsp(tag, ea, eu);
    endtask

    task automatic model_req(string tag, logic [31:0] a, logic [1:0] t);
        logic [32:0] e;
        e = expect_rsp(a, t, model_cfg);
        one_req(tag, a, t, e[31:0], e[32]);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        checks++;
        if (rsp_valid !== 1'b0 || req_ready !== 1'b1) begin
            fails++;
            $display("FAIL R11: got valid=%0b ready=%0b, expected valid=0 ready=1", rsp_valid, req_ready);
        end
        one_req("R11 no swizzle after reset", 32'h200, 2'd1, 32'h200, 1'b0);

        // R3 interleaved, CPU XOR off
        write_cfg(32'h6);
        one_req("R3 X bit9",      32'h200, 2'd1, 32'h240, 1'b0);
        one_req("R3 X bits9+10",  32'h600, 2'd1, 32'h600, 1'b0);
        one_req("R3 Y bits9+10",  32'h600, 2'd2, 32'h640, 1'b0);
        one_req("R1 linear",      32'h200, 2'd0, 32'h200, 1'b0);
        one_req("R1 reserved kind", 32'h200, 2'd3, 32'h200, 1'b0);

        // R4 CPU XOR with bit 11
        write_cfg(32'h2);
        one_req("R4 X bit11",     32'h800, 2'd1, 32'h840, 1'b0);
        one_req("R4 Y bits9+11",  32'hA00, 2'd2, 32'hA00, 1'b0);

        // R5 CPU XOR with bit 17
        write_cfg(32'hA);
        one_req("R5 Y bit17",     32'h20000, 2'd2, 32'h20040, 1'b1);
        one_req("R5 X 9+10+17",   32'h20600, 2'd1, 32'h20640, 1'b1);
        one_req("R5 linear safe", 32'h20000, 2'd0, 32'h20000, 1'b0);

        // R2 non-interleaved modes
        write_cfg(32'h1);
        one_req("R2 asym",        32'h200, 2'd1, 32'h200, 1'b0);
        write_cfg(32'h3);
        one_req("R2 reserved",    32'h200, 2'd2, 32'h200, 1'b0);

        // R6 size-derived method
        write_cfg(32'h30);
        one_req("R6 equal X bit10", 32'h400, 2'd1, 32'h440, 1'b0);
        write_cfg(32'h2A);
        one_req("R6 unequal overrides", 32'h20600, 2'd1, 32'h20600, 1'b0);

        // R7 unreadable configuration
        write_cfg(32'hFFFF_FFFF);
        one_req("R7 unknown X",   32'h200, 2'd1, 32'h200, 1'b1);
        one_req("R7 linear",      32'h200, 2'd0, 32'h200, 1'b0);

        // R10 same-cycle configuration write
        @(negedge clk);
        cfg_we = 1'b1; cfg_word = 32'h6;
        req_valid = 1'b1; req_addr = 32'h200; req_tile = 2'd1;
        @(negedge clk);
        cfg_we = 1'b0; req_valid = 1'b0;
        check_rsp("R10 old config used", 32'h200, 1'b1);
        model_cfg = 32'h6;
        one_req("R10 new config used", 32'h200, 2'd1, 32'h240, 1'b0);

        // R9 stall and hold
        @(negedge clk);
        rsp_ready = 1'b0;
        req_valid = 1'b1; req_addr = 32'h200; req_tile = 2'd2;
        @(negedge clk);
        req_addr = 32'h600; req_tile = 2'd1;
        check_rsp("R9 first response", 32'h240, 1'b0);
        checks++;
        if (req_ready !== 1'b0) begin
            fails++;
            $display("FAIL R9: got req_ready=%0b, expected 0", req_ready);
        end
        @(negedge clk);
        check_rsp("R9 held while stalled", 32'h240, 1'b0);
        rsp_ready = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check_rsp("R9 second after release", 32'h600, 1'b0);
        @(negedge clk);
        checks++;
        if (rsp_valid !== 1'b0) begin
            fails++;
            $display("FAIL R9: got rsp_valid=%0b, expected 0", rsp_valid);
        end

        // Random mix, R8 and full model
        for (int i = 0; i < 400; i++) begin
            if (($urandom % 6) == 0) begin
                logic [31:0] w;
                w = $urandom;
                if (($urandom % 8) == 0) w = 32'hFFFF_FFFF;
                write_cfg(w);
            end
            model_req("R8 random", $urandom, 2'($urandom));
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule